// File: doc/BRIEF.md
# Coherence Snoop Filter Directory

This block sits inside a coherent interconnect and remembers, for a small set of line addresses, which ports currently hold a copy of each line and which ports have asked for it and are still waiting. Whenever a port issues a shared read or an upgrade, the directory answers with the set of ports that have to be snooped. That set is every recorded holder except the requesting port, so ports without a copy never see snoop traffic.

Two streams update the stored vectors. The first is the lookup stream: reads, upgrades and eviction notices. The second is the response stream. A response names the line, the port that supplied the data and the port that receives it. When the response completes an exclusive grant, the receiving port becomes the only holder of the line.

Tracking storage is a fully associative set of entries. A lookup that misses takes the lowest-numbered free entry. When every entry is in use, a lookup that would need a new entry is held back until an eviction releases one.

Top module: `sfd_directory`

## Requirements
- R1: After reset every entry is free, `snp_valid` is 0, and `lk_ready` is 1.
- R2: A shared read (`lk_cmd` 0, or the spare code 3) sets the source port's bit in the entry's requested vector and does not change its holder vector.
- R3: The snoop mask returned for a read or an upgrade equals the entry's holder vector with the source port's bit cleared. Bit i of the mask stands for port i.
- R4: For an accepted read or upgrade, `snp_valid` and `snp_mask` appear in the cycle after the lookup is accepted and last exactly one cycle. An eviction notice produces no result.
- R5: A response to a tracked line clears the requested bits of both the requester and the responder, and adds the requester to the holder vector.
- R6: An upgrade (`lk_cmd` 1) sets the source port's requested bit and returns every other holder as the snoop mask, so those holders can be invalidated.
- R7: A response with `rsp_excl` set leaves the requester as the only holder of the line.
- R8: A read or upgrade that misses allocates the lowest free entry with empty vectors, so its mask is 0. If no entry is free, `lk_ready` is 0, and the lookup is neither recorded nor answered.
- R9: An eviction notice (`lk_cmd` 2) clears the source port's holder bit. The entry becomes free once both of its vectors are zero. An eviction to an untracked line has no effect and is never stalled.
- R10: A response whose address is not tracked changes no entry.
- R11: If a response and a lookup arrive in the same cycle, the lookup sees the entry after the response has been applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup present |
| lk_ready | output | 1 | Lookup accepted this cycle (0 = stalled, no free entry) |
| lk_addr | input | AW | Line address of the lookup |
| lk_src | input | PW | Requesting port number |
| lk_cmd | input | 2 | 0 shared read, 1 upgrade, 2 eviction notice, 3 treated as shared read |
| snp_valid | output | 1 | Snoop mask valid |
| snp_mask | output | NP | Ports to snoop |
| rsp_valid | input | 1 | Response passing through |
| rsp_addr | input | AW | Line address of the response |
| rsp_responder | input | PW | Port that supplied the data |
| rsp_requester | input | PW | Port that receives the data |
| rsp_excl | input | 1 | Response completes an exclusive (upgrade) grant |

## Verification
`lk_ready` is combinational in the current cycle's lookup and the stored state. The bench drives its inputs on the falling edge and samples `lk_ready` 1 ns later, before any rising edge intervenes. The snoop result passes through one register, so the bench reads `snp_valid` and `snp_mask` at the next falling edge, after the single rising edge that captures them. Stored vector changes have no direct outputs. They show up in the masks of later lookups and in whether allocations stall, and a bench model updated in the same order as R11 predicts both.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
    typedef enum logic [1:0] {
        CMD_RDSH  = 2'd0,
        CMD_UPG   = 2'd1,
        CMD_EVICT = 2'd2,
        CMD_SPARE = 2'd3
    } sfd_cmd_e;
endpackage

// File: rtl/sfd_tag_match.sv
// Parallel compare of one address against every valid tag.
module sfd_tag_match #(
    parameter int NE = 4,
    parameter int AW = 16
) (
    input  logic [NE-1:0]         vld,
    input  logic [NE-1:0][AW-1:0] tags,
    input  logic [AW-1:0]         addr,
    output logic                  hit,
    output logic [((NE>1)?$clog2(NE):1)-1:0] idx
);
    localparam int IW = (NE > 1) ? $clog2(NE) : 1;

    logic [NE-1:0] eq;

    for (genvar g = 0; g < NE; g++) begin : g_cmp
        assign eq[g] = vld[g] && (tags[g] == addr);
    end

    always_comb begin
        idx = '0;
        for (int i = NE - 1; i >= 0; i--) begin
            if (eq[i]) idx = IW'(i);
        end
        hit = |eq;
    end
endmodule

// File: rtl/sfd_free_pick.sv
// Lowest-numbered free entry.
module sfd_free_pick #(
    parameter int NE = 4
) (
    input  logic [NE-1:0] vld,
    output logic          any_free,
    output logic [((NE>1)?$clog2(NE):1)-1:0] idx
);
    localparam int IW = (NE > 1) ? $clog2(NE) : 1;

    always_comb begin
        idx = '0;
        for (int i = NE - 1; i >= 0; i--) begin
            if (!vld[i]) idx = IW'(i);
        end
        any_free = ~&vld;
    end
endmodule

// File: rtl/sfd_directory.sv
module sfd_directory #(
    parameter int NP = 4,
    parameter int NE = 4,
    parameter int AW = 16,
    parameter int PW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lk_valid,
    output logic          lk_ready,
    input  logic [AW-1:0] lk_addr,
    input  logic [PW-1:0] lk_src,
    input  logic [1:0]    lk_cmd,
    output logic          snp_valid,
    output logic [NP-1:0] snp_mask,
    input  logic          rsp_valid,
    input  logic [AW-1:0] rsp_addr,
    input  logic [PW-1:0] rsp_responder,
    input  logic [PW-1:0] rsp_requester,
    input  logic          rsp_excl
);
    import sfd_pkg::*;

    localparam int IW = (NE > 1) ? $clog2(NE) : 1;

    typedef struct packed {
        logic [NE-1:0]         vld;
        logic [NE-1:0][AW-1:0] tag;
        logic [NE-1:0][NP-1:0] req;
        logic [NE-1:0][NP-1:0] hold;
        logic                  snp_vld;
        logic [NP-1:0]         snp_mask;
    } sfd_state_t;

    sfd_state_t s_d, s_q;

    logic          lk_hit, rs_hit, any_free;
    logic [IW-1:0] lk_idx, rs_idx, free_idx;
    sfd_cmd_e      cmd;

    assign cmd = sfd_cmd_e'(lk_cmd);

    sfd_tag_match #(.NE(NE), .AW(AW)) u_lk_match (
        .vld (s_q.vld),
        .tags(s_q.tag),
        .addr(lk_addr),
        .hit (lk_hit),
        .idx (lk_idx)
    );

    sfd_tag_match #(.NE(NE), .AW(AW)) u_rs_match (
        .vld (s_q.vld),
        .tags(s_q.tag),
        .addr(rsp_addr),
        .hit (rs_hit),
        .idx (rs_idx)
    );

    sfd_free_pick #(.NE(NE)) u_free (
        .vld     (s_q.vld),
        .any_free(any_free),
        .idx     (free_idx)
    );

    always_comb begin
        logic [NP-1:0] src_bit, rqr_bit, rsd_bit;
        logic [IW-1:0] e;

        s_d          = s_q;
        s_d.snp_vld  = 1'b0;
        s_d.snp_mask = '0;
        src_bit      = NP'(1) << lk_src;
        rqr_bit      = NP'(1) << rsp_requester;
        rsd_bit      = NP'(1) << rsp_responder;
        e            = lk_hit ? lk_idx : free_idx;

        lk_ready = !(lk_valid && cmd != CMD_EVICT && !lk_hit && !any_free);

        // Responses are folded in before the lookup of the same cycle.
        if (rsp_valid && rs_hit) begin
            s_d.req[rs_idx]  = s_d.req[rs_idx] & ~rqr_bit & ~rsd_bit;
            s_d.hold[rs_idx] = rsp_excl ? rqr_bit : (s_d.hold[rs_idx] | rqr_bit);
        end

        if (lk_valid && lk_ready) begin
            if (cmd == CMD_EVICT) begin
                if (lk_hit) begin
                    s_d.hold[lk_idx] = s_d.hold[lk_idx] & ~src_bit;
                    if (s_d.hold[lk_idx] == '0 && s_d.req[lk_idx] == '0) begin
                        s_d.vld[lk_idx] = 1'b0;
                    end
                end
            end else begin
                if (!lk_hit) begin
                    s_d.vld[e]  = 1'b1;
                    s_d.tag[e]  = lk_addr;
                    s_d.req[e]  = '0;
                    s_d.hold[e] = '0;
                end
                s_d.snp_mask = s_d.hold[e] & ~src_bit;
                s_d.snp_vld  = 1'b1;
                s_d.req[e]   = s_d.req[e] | src_bit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign snp_valid = s_q.snp_vld;
    assign snp_mask  = s_q.snp_mask;
endmodule

// File: rtl/sfd_directory_chk.sv
module sfd_directory_chk #(
    parameter int NP = 4,
    parameter int PW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lk_valid,
    input logic          lk_ready,
    input logic [PW-1:0] lk_src,
    input logic [1:0]    lk_cmd,
    input logic          snp_valid,
    input logic [NP-1:0] snp_mask
);
    a_r3_mask_excl_src: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> ((snp_mask & (NP'(1) << $past(lk_src))) == '0));

    a_r4_result_next: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready && lk_cmd != 2'd2) |=> snp_valid);

    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_valid && lk_ready && lk_cmd != 2'd2) |=> !snp_valid);

    a_r8_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_ready |-> (lk_valid && lk_cmd != 2'd2));

    a_r9_evict_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_cmd == 2'd2) |-> lk_ready);
endmodule

bind sfd_directory sfd_directory_chk #(.NP(NP), .PW(PW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_valid),
    .lk_ready (lk_ready),
    .lk_src   (lk_src),
    .lk_cmd   (lk_cmd),
    .snp_valid(snp_valid),
    .snp_mask (snp_mask)
);

// File: tb/sfd_directory_test.sv
module sfd_directory_test;
    localparam int NP = 4;
    localparam int NE = 4;
    localparam int AW = 16;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic          lk_ready;
    logic [AW-1:0] lk_addr = '0;
    logic [PW-1:0] lk_src = '0;
    logic [1:0]    lk_cmd = '0;
    logic          snp_valid;
    logic [NP-1:0] snp_mask;
    logic          rsp_valid = 1'b0;
    logic [AW-1:0] rsp_addr = '0;
    logic [PW-1:0] rsp_responder = '0;
    logic [PW-1:0] rsp_requester = '0;
    logic          rsp_excl = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model of the directory.
    bit            mv[NE];
    logic [AW-1:0] mt[NE];
    logic [NP-1:0] mr[NE];
    logic [NP-1:0] mh[NE];

    always #10 clk = ~clk;

    sfd_directory #(.NP(NP), .NE(NE), .AW(AW), .PW(PW)) uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
        .lk_src(lk_src), .lk_cmd(lk_cmd),
        .snp_valid(snp_valid), .snp_mask(snp_mask),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_responder(rsp_responder), .rsp_requester(rsp_requester),
        .rsp_excl(rsp_excl)
    );

    function automatic int find(logic [AW-1:0] a);
        for (int i = 0; i < NE; i++) if (mv[i] && mt[i] == a) return i;
        return -1;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(string tag, bit lv, logic [AW-1:0] la, int ls, int lc,
                       bit rv, logic [AW-1:0] ra, int rd, int rq, bit rx);
        int li, fi, ri, e;
        bit er, sv;
        logic [NP-1:0] sm;
        lk_valid = lv; lk_addr = la; lk_src = PW'(ls); lk_cmd = 2'(lc);
        rsp_valid = rv; rsp_addr = ra; rsp_responder = PW'(rd);
        rsp_requester = PW'(rq); rsp_excl = rx;
        #1;
        li = find(la);
        fi = -1;
        for (int i = 0; i < NE; i++) if (!mv[i] && fi < 0) fi = i;
        er = !(lv && lc != 2 && li < 0 && fi < 0);
        check({tag, " ready"}, 32'(lk_ready), 32'(er));
        ri = find(ra);
        if (rv && ri >= 0) begin
            mr[ri] = mr[ri] & ~(NP'(1) << rq) & ~(NP'(1) << rd);
            mh[ri] = rx ? (NP'(1) << rq) : (mh[ri] | (NP'(1) << rq));
        end
        sv = 0; sm = '0;
        if (lv && er) begin
            if (lc == 2) begin
                if (li >= 0) begin
                    mh[li] = mh[li] & ~(NP'(1) << ls);
                    if (mh[li] == '0 && mr[li] == '0) mv[li] = 0;
                end
            end else begin
                e = (li >= 0) ? li : fi;
                if (li < 0) begin
                    mv[e] = 1; mt[e] = la; mr[e] = '0; mh[e] = '0;
                end
                sm = mh[e] & ~(NP'(1) << ls);
                mr[e] = mr[e] | (NP'(1) << ls);
                sv = 1;
            end
        end
        @(negedge clk);
        check({tag, " snp_valid"}, 32'(snp_valid), 32'(sv));
        if (sv) check({tag, " snp_mask"}, 32'(snp_mask), 32'(sm));
    endtask

    task automatic rd(string tag, logic [AW-1:0] a, int p, int c);
        cyc(tag, 1, a, p, c, 0, '0, 0, 0, 0);
    endtask

    task automatic rs(string tag, logic [AW-1:0] a, int rdp, int rqp, bit x);
        cyc(tag, 0, '0, 0, 0, 1, a, rdp, rqp, x);
    endtask

    localparam logic [AW-1:0] A = 16'h0081, B = 16'h0102, C = 16'h0203,
                              D = 16'h0304, E = 16'h0405, F = 16'h0506;

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NE; i++) begin
            mv[i] = 0; mt[i] = '0; mr[i] = '0; mh[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset snp_valid", 32'(snp_valid), 0);
        check("R1 reset ready", 32'(lk_ready), 1);
        @(negedge clk);

        rd("R8 miss alloc", A, 0, 0);
        rd("R2 holders unchanged", A, 1, 0);
        rs("R5 response", A, 3, 0, 0);
        rd("R3 mask other holder", A, 2, 3);
        rd("R3 excl own bit", A, 0, 0);
        rs("R5 second holder", A, 0, 2, 0);
        rd("R6 upgrade snoops holders", A, 1, 1);
        rs("R7 exclusive grant", A, 0, 1, 1);
        rd("R7 single holder", A, 3, 0);
        rs("R10 untracked response", B, 0, 2, 0);
        rd("R10 untracked alloc", B, 1, 0);
        rd("R9 evict holder", A, 1, 2);
        rd("R9 holder cleared", A, 2, 0);
        rd("R8 fill", C, 0, 0);
        rd("R8 fill", D, 0, 0);
        rd("R8 full stall", E, 2, 1);
        rd("R9 evict untracked", F, 0, 2);
        rs("R5 clear pend", B, 0, 1, 0);
        rd("R9 evict frees", B, 1, 2);
        rd("R9 freed alloc", E, 2, 0);
        cyc("R11 same cycle", 1, A, 2, 0, 1, A, 0, 3, 0);

        for (int n = 0; n < 3000; n++) begin
            logic [AW-1:0] pool[6];
            pool[0] = A; pool[1] = B; pool[2] = C;
            pool[3] = D; pool[4] = E; pool[5] = F;
            cyc("R3/R4 random", ($urandom_range(0, 3) != 0),
                pool[$urandom_range(0, 5)], int'($urandom_range(0, NP-1)),
                int'($urandom_range(0, 3)), ($urandom_range(0, 2) == 0),
                pool[$urandom_range(0, 5)], int'($urandom_range(0, NP-1)),
                int'($urandom_range(0, NP-1)), ($urandom_range(0, 3) == 0));
        end
        lk_valid = 0; rsp_valid = 0;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule